// File: doc/BRIEF.md
# Dual-Bank Flash Mirror Swap Remapper

This block sits between a processor's flash read port and a flash array split into a lower and an upper half of equal size. The upper copy of a software image lives exactly 0x80000 above the lower copy. Software can ask for a hot swap by writing a one to a swap control bit. The block holds the request until no fetch, program or erase is running. It then flips a single mapping flag and empties its one-line read buffer, all in one cycle.

While the flag is set, read addresses are remapped by inverting the top address bit. A read aimed at either half is therefore served from the other half, until the next swap turns the mapping back. Program and erase requests never go through this translation. Software that rewrites an image after a swap must therefore give the physical location. For example, once swapped, a read at 0x03FEC returns the word stored at 0x83FEC, and a program meant for that word must be sent to 0x83FEC.

The flash array is a behavioural model. It keeps a parameterised number of 128-bit lines per half, and program or erase keeps it busy for a fixed number of cycles.

Top module: `flash_mirror_remap`

## Requirements
- R1: After a synchronous active-low reset, `mirror_swapped` is 0, no swap is pending, `pf_flush` and `rd_valid` are 0, and the line buffer is empty, so the first read takes the miss latency.
- R2: While `mirror_swapped` is 0, a read returns the 32-bit word at `rd_addr`: the 128-bit line at `rd_addr[19:4]`, with word `rd_addr[3:2]` taken from bits `32*rd_addr[3:2]` upward.
- R3: While `mirror_swapped` is 1, a read at address A returns the word stored at A XOR 0x80000, for addresses in both halves.
- R4: Each committed swap inverts `mirror_swapped`, so a second swap restores the identity mapping. Without a commit the flag holds its value.
- R5: Program and erase always use `pe_addr` as a physical address, whatever the mapping state. A program (`pe_erase`=0) ANDs `pe_wdata` into the addressed word. An erase (`pe_erase`=1) sets the whole addressed 128-bit line to all ones. After reset every line reads as all ones.
- R6: A swap request (`cfg_wr`=1 with `cfg_swap`=1) made while a fetch, program or erase is in progress is held pending. It commits in the first cycle the banks are idle, and `mirror_swapped` changes at the end of that cycle. Further requests while one is pending are absorbed into it.
- R7: In the commit cycle, `rd_gnt` and `pe_gnt` are 0, so a read waiting in that cycle is granted later and sees the new mapping.
- R8: `pf_flush` is 1 for exactly the commit cycle. The line buffer is empty after it, so the next read takes the miss latency.
- R9: A granted read whose physical line is in the buffer raises `rd_valid` one cycle after the grant. A miss raises it two cycles after the grant and loads the line into the buffer, tagged with its physical line address.
- R10: A program or erase to the physical line held in the buffer empties the buffer.
- R11: Neither reads nor program/erase are granted while a miss fetch is in flight, or for PE_CYCLES cycles after a program or erase grant. When both requests arrive in an idle cycle, the read wins.
- R12: A write with `cfg_swap`=0 has no effect: no flush, no change of `mirror_swapped`, and the buffered line stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe of the swap control bit |
| cfg_swap | input | 1 | Written value; 1 requests a swap |
| mirror_swapped | output | 1 | Current mapping state, 1 = halves swapped |
| pf_flush | output | 1 | One-cycle pulse when a swap commits and the line buffer is emptied |
| rd_req | input | 1 | Read request, held until granted |
| rd_addr | input | ADDR_W | Logical byte address of the read |
| rd_gnt | output | 1 | Read accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WORD_W | Read word |
| pe_req | input | 1 | Program/erase request, held until granted |
| pe_erase | input | 1 | 1 = erase line, 0 = program word |
| pe_addr | input | ADDR_W | Physical byte address, never remapped |
| pe_wdata | input | WORD_W | Program data |
| pe_gnt | output | 1 | Program/erase accepted this cycle |

## Verification
The bench uses a 20-bit address, so the half boundary sits at bit 19 and the 0x80000 mirror offset is exercised directly. It keeps six line-index bits per half, so the model holds 128 lines, and it shortens the program/erase busy window to PE_CYCLES=3. With so short a window, the bench can check every cycle between a program grant and a deferred swap commit: that grants are blocked, that the flush pulse falls on the right cycle, and that the flag toggles only once after two writes. The bench tells a buffer hit from a miss by measuring read latency, and so sees flushes and coherence kills without looking inside the block.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
// Shared types of the flash mirror remapper.
package fm_pkg;

    // Read path phase: idle/accepting, or waiting on an array line fetch.
    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_FETCH = 1'b1
    } rd_phase_e;

    // Operation kind on the physical program/erase port.
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } pe_op_e;

endpackage

// File: rtl/fm_swap_ctrl.sv
`timescale 1ns/1ps
// Swap controller: latches a software swap request, commits it in the first
// idle cycle of the banks, and toggles the mapping flag at that commit.
// Assumes banks_idle reflects fetches and program/erase only; the parent
// blocks new grants during the commit cycle.
module fm_swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic banks_idle,
    output logic swapped,
    output logic pending,
    output logic commit
);

    // Commit whenever a request waits and nothing uses the banks.
    assign commit = pending && banks_idle;

    // Track the pending request and the mapping flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            swapped <= 1'b0;
        end else if (commit) begin
            pending <= 1'b0;
            swapped <= ~swapped;
        end else if (swap_req) begin
            pending <= 1'b1;
        end
    end

    // R4: a commit flips the mapping flag
    a_r4_commit_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (swapped != $past(swapped)));

    // R4: without a commit the flag holds
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(swapped));

    // R6: the commit consumes the pending request
    a_r6_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pending);

endmodule

// File: rtl/fm_prefetch_buf.sv
`timescale 1ns/1ps
// One-line read buffer tagged with the physical line address it holds.
// Emptied by a swap flush or by a program/erase to the held line; a flush
// and a fill never coincide because a swap waits for the fetch to finish.
module fm_prefetch_buf #(
    parameter int TAG_W  = 16,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              pe_touch,
    input  logic [TAG_W-1:0]  pe_tag,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [LINE_W-1:0] line
);

    logic             valid;
    logic [TAG_W-1:0] tag;
    logic             kill;

    // Program/erase to the buffered line makes it stale.
    assign kill = pe_touch && valid && (pe_tag == tag);
    // Lookup compares the physical line tag.
    assign hit  = valid && (tag == look_tag);

    // Hold, fill or empty the single line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            line  <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (fill) begin
            valid <= 1'b1;
            tag   <= fill_tag;
            line  <= fill_line;
        end else if (kill) begin
            valid <= 1'b0;
        end
    end

    // R8: a flush leaves the buffer empty
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid);

    // R9: a fill without flush leaves a valid line tagged as filled
    a_r9_fill_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !flush) |=> (valid && tag == $past(fill_tag)));

    // R10: a program/erase to the held line empties it
    a_r10_kill_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !fill) |=> !valid);

endmodule

// File: rtl/fm_flash_array.sv
`timescale 1ns/1ps
// Behavioural dual-half flash array. Keeps 2**IDX_W lines per half; line
// address bits above the index alias. Reads are combinational on a line tag;
// program ANDs a word, erase sets a line to ones, and either keeps the array
// busy for PE_CYCLES cycles. Assumes PE_CYCLES >= 1 and
// OFS_W + IDX_W < ADDR_W.
module fm_flash_array
    import fm_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LINE_W    = 128,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 6,
    parameter int PE_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-$clog2(LINE_W/8)-1:0] rd_tag,
    output logic [LINE_W-1:0]          rd_line,
    input  logic                       pe_go,
    input  pe_op_e                     pe_op,
    input  logic [ADDR_W-1:0]          pe_addr,
    input  logic [WORD_W-1:0]          pe_wdata,
    output logic                       pe_busy
);

    localparam int OFS_W   = $clog2(LINE_W / 8);
    localparam int BYTE_W  = $clog2(WORD_W / 8);
    localparam int WSEL_W  = OFS_W - BYTE_W;
    localparam int LINES   = 2 ** (IDX_W + 1);
    localparam int CNT_W   = $clog2(PE_CYCLES + 2);

    logic [LINE_W-1:0] mem [LINES];
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W:0]    rd_idx;
    logic [IDX_W:0]    pe_idx;
    logic [WSEL_W-1:0] pe_wsel;
    logic              unused_addr_bits;

    // Storage index: half select bit plus the low line-index bits.
    assign rd_idx  = {rd_tag[ADDR_W-OFS_W-1], rd_tag[IDX_W-1:0]};
    assign pe_idx  = {pe_addr[ADDR_W-1], pe_addr[OFS_W+IDX_W-1:OFS_W]};
    assign pe_wsel = pe_addr[OFS_W-1:BYTE_W];
    assign unused_addr_bits = ^{rd_tag, pe_addr};

    // Line read for the fetch path.
    assign rd_line = mem[rd_idx];
    assign pe_busy = (cnt != '0);

    // Apply program/erase and reset every line to the erased state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '1;
        end else if (pe_go) begin
            if (pe_op == OP_ERASE) begin
                mem[pe_idx] <= '1;
            end else begin
                mem[pe_idx][pe_wsel*WORD_W +: WORD_W] <=
                    mem[pe_idx][pe_wsel*WORD_W +: WORD_W] & pe_wdata;
            end
        end
    end

    // Count the busy window of a program/erase.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (pe_go)   cnt <= CNT_W'(PE_CYCLES);
        else if (pe_busy) cnt <= cnt - 1'b1;
    end

    // R11: no new operation while one is running
    a_r11_pe_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        pe_go |-> !pe_busy);

    // R11: a started operation makes the array busy
    a_r11_pe_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pe_go |=> pe_busy);

endmodule

// File: rtl/flash_mirror_remap.sv
`timescale 1ns/1ps
// Top of the flash mirror remapper. Translates read addresses by XOR of the
// top address bit with the mapping flag, serves reads through a one-line
// buffer, passes program/erase through untranslated, and commits software
// swap requests only while the banks are idle.
module flash_mirror_remap
    import fm_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LINE_W    = 128,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 6,
    parameter int PE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_swap,
    output logic              mirror_swapped,
    output logic              pf_flush,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_gnt,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pe_req,
    input  logic              pe_erase,
    input  logic [ADDR_W-1:0] pe_addr,
    input  logic [WORD_W-1:0] pe_wdata,
    output logic              pe_gnt
);

    localparam int OFS_W  = $clog2(LINE_W / 8);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFS_W - BYTE_W;
    localparam int TAG_W  = ADDR_W - OFS_W;

    rd_phase_e         phase;
    logic [TAG_W-1:0]  fetch_tag;
    logic [WSEL_W-1:0] fetch_wsel;
    logic [ADDR_W-1:0] phys_addr;
    logic [TAG_W-1:0]  phys_tag;
    logic [WSEL_W-1:0] phys_wsel;
    logic              fetch_busy;
    logic              arr_busy;
    logic              banks_idle;
    logic              commit;
    logic              swap_pending;
    logic              buf_hit;
    logic [LINE_W-1:0] buf_line;
    logic [LINE_W-1:0] arr_line;
    logic              unused_low_bits;

    // Mirror translation: flip the half select bit while swapped.
    assign phys_addr = rd_addr ^ {mirror_swapped, {(ADDR_W-1){1'b0}}};
    assign phys_tag  = phys_addr[ADDR_W-1:OFS_W];
    assign phys_wsel = phys_addr[OFS_W-1:BYTE_W];
    assign unused_low_bits = ^phys_addr[BYTE_W-1:0];

    // Bank activity and grant arbitration; the commit cycle grants nothing.
    assign fetch_busy = (phase == RD_FETCH);
    assign banks_idle = !fetch_busy && !arr_busy;
    assign rd_gnt     = rd_req && banks_idle && !commit;
    assign pe_gnt     = pe_req && banks_idle && !commit && !rd_req;
    assign pf_flush   = commit;

    fm_swap_ctrl u_swap (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_req   (cfg_wr && cfg_swap),
        .banks_idle (banks_idle),
        .swapped    (mirror_swapped),
        .pending    (swap_pending),
        .commit     (commit)
    );

    fm_prefetch_buf #(
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (commit),
        .fill      (fetch_busy),
        .fill_tag  (fetch_tag),
        .fill_line (arr_line),
        .pe_touch  (pe_gnt),
        .pe_tag    (pe_addr[ADDR_W-1:OFS_W]),
        .look_tag  (phys_tag),
        .hit       (buf_hit),
        .line      (buf_line)
    );

    fm_flash_array #(
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W),
        .PE_CYCLES (PE_CYCLES)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_tag   (fetch_tag),
        .rd_line  (arr_line),
        .pe_go    (pe_gnt),
        .pe_op    (pe_erase ? OP_ERASE : OP_PROG),
        .pe_addr  (pe_addr),
        .pe_wdata (pe_wdata),
        .pe_busy  (arr_busy)
    );

    // Read pipeline: answer hits next cycle, fetch misses from the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= RD_IDLE;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            fetch_tag  <= '0;
            fetch_wsel <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (phase)
                RD_IDLE: begin
                    if (rd_gnt) begin
                        if (buf_hit) begin
                            rd_valid <= 1'b1;
                            rd_data  <= buf_line[phys_wsel*WORD_W +: WORD_W];
                        end else begin
                            phase      <= RD_FETCH;
                            fetch_tag  <= phys_tag;
                            fetch_wsel <= phys_wsel;
                        end
                    end
                end
                RD_FETCH: begin
                    rd_valid <= 1'b1;
                    rd_data  <= arr_line[fetch_wsel*WORD_W +: WORD_W];
                    phase    <= RD_IDLE;
                end
                default: phase <= RD_IDLE;
            endcase
        end
    end

    // R6: a swap only commits with no fetch and no program/erase running
    a_r6_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!fetch_busy && !arr_busy && swap_pending));

    // R7: nothing is granted in the commit cycle
    a_r7_no_grant_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        pf_flush |-> (!rd_gnt && !pe_gnt));

    // R11: read and program/erase are never granted together
    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_gnt && pe_gnt));

    // R11: a running program/erase blocks reads
    a_r11_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        arr_busy |-> !rd_gnt);

    // R9: a miss fetch delivers data in the following cycle
    a_r9_miss_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy |=> rd_valid);

endmodule

// File: tb/test_flash_mirror_remap.sv
`timescale 1ns/1ps
// Directed bench for the flash mirror remapper.
module test_flash_mirror_remap;

    localparam int AW = 20;
    localparam int WW = 32;
    localparam int BP_PE = 3;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_swap = 1'b0;
    logic          mirror_swapped, pf_flush;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_gnt, rd_valid;
    logic [WW-1:0] rd_data;
    logic          pe_req = 1'b0, pe_erase = 1'b0;
    logic [AW-1:0] pe_addr = '0;
    logic [WW-1:0] pe_wdata = '0;
    logic          pe_gnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    flash_mirror_remap #(
        .ADDR_W(AW), .LINE_W(128), .WORD_W(WW), .IDX_W(6), .PE_CYCLES(BP_PE)
    ) i_flash_mirror_remap (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_swap(cfg_swap),
        .mirror_swapped(mirror_swapped), .pf_flush(pf_flush),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .pe_req(pe_req), .pe_erase(pe_erase), .pe_addr(pe_addr),
        .pe_wdata(pe_wdata), .pe_gnt(pe_gnt)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Issue one read, return its data and latency counted from the grant.
    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d,
                           output int lat);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        #1;
        while (!rd_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 8) begin @(negedge clk); lat++; end
        d = rd_data;
    endtask

    task automatic rd_check(input string rq, input logic [AW-1:0] a,
                            input logic [31:0] exp_d, input int exp_lat);
        logic [31:0] d;
        int lat;
        do_read(a, d, lat);
        chk(rq, $sformatf("data @%h", a), d, exp_d);
        chk(rq, $sformatf("latency @%h", a), lat, exp_lat);
    endtask

    // Issue one program or erase and wait out its busy window.
    task automatic do_pe(input logic [AW-1:0] a, input logic er,
                         input logic [31:0] wd);
        @(negedge clk);
        pe_req = 1'b1; pe_addr = a; pe_erase = er; pe_wdata = wd;
        #1;
        while (!pe_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        pe_req = 1'b0;
        repeat (BP_PE) @(negedge clk);
    endtask

    // Swap with idle banks: commit one cycle after the write.
    task automatic do_swap(input logic exp_after);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_swap = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_swap = 1'b0;
        #1;
        chk("R8", "flush pulse in commit cycle", pf_flush, 1);
        @(negedge clk);
        chk("R4", "mapping flag after swap", mirror_swapped, exp_after);
        chk("R8", "flush lasts one cycle", pf_flush, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "flag in reset", mirror_swapped, 0);
        chk("R1", "rd_valid in reset", rd_valid, 0);
        chk("R1", "flush in reset", pf_flush, 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "flag after reset", mirror_swapped, 0);
        rd_check("R1", 20'h00400, ONES, 2);
    endtask

    task automatic t_identity();
        do_pe(20'h03FEC, 1'b0, 32'hA5A5_0F0F);
        do_pe(20'h83FEC, 1'b0, 32'h1234_5678);
        rd_check("R2", 20'h03FEC, 32'hA5A5_0F0F, 2);
        rd_check("R9", 20'h03FEC, 32'hA5A5_0F0F, 1);
        rd_check("R2", 20'h03FE8, ONES, 1);
        rd_check("R2", 20'h83FEC, 32'h1234_5678, 2);
    endtask

    task automatic t_program_and();
        do_pe(20'h83FEC, 1'b0, 32'hFFFF_00FF);
        rd_check("R10", 20'h83FEC, 32'h1234_0078, 2);
    endtask

    task automatic t_priority();
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 20'h83FEC;
        pe_req = 1'b1; pe_addr = 20'h00200; pe_erase = 1'b0; pe_wdata = ONES;
        #1;
        chk("R11", "read granted first", rd_gnt, 1);
        chk("R11", "program held back", pe_gnt, 0);
        @(negedge clk);
        rd_req = 1'b0; pe_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_swap();
        do_swap(1'b1);
        rd_check("R3", 20'h03FEC, 32'h1234_0078, 2);
        rd_check("R3", 20'h83FEC, 32'hA5A5_0F0F, 2);
        do_pe(20'h03FE8, 1'b0, 32'hC0DE_BEEF);
        rd_check("R5", 20'h83FE8, 32'hC0DE_BEEF, 2);
        rd_check("R5", 20'h03FE8, ONES, 2);
        do_pe(20'h83FE0, 1'b1, 32'h0);
        rd_check("R5", 20'h03FEC, ONES, 2);
    endtask

    task automatic t_ignored_write();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_swap = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        chk("R12", "no flush on zero write", pf_flush, 0);
        @(negedge clk);
        chk("R12", "flag unchanged", mirror_swapped, 1);
        rd_check("R12", 20'h03FEC, ONES, 1);
    endtask

    task automatic t_pending();
        @(negedge clk);
        pe_req = 1'b1; pe_addr = 20'h00100; pe_erase = 1'b0; pe_wdata = 32'h0;
        #1;
        chk("R11", "program granted", pe_gnt, 1);
        @(negedge clk);
        pe_req = 1'b0;
        cfg_wr = 1'b1; cfg_swap = 1'b1;
        rd_req = 1'b1; rd_addr = 20'h03FEC;
        for (int k = 1; k <= BP_PE; k++) begin
            #1;
            chk("R6", $sformatf("no commit while busy +%0d", k), pf_flush, 0);
            chk("R11", $sformatf("read blocked while busy +%0d", k), rd_gnt, 0);
            @(negedge clk);
            if (k == 2) begin cfg_wr = 1'b0; cfg_swap = 1'b0; end
        end
        #1;
        chk("R6", "commit on first idle cycle", pf_flush, 1);
        chk("R7", "read stalled in commit cycle", rd_gnt, 0);
        chk("R6", "flag not yet changed", mirror_swapped, 1);
        @(negedge clk);
        #1;
        chk("R6", "single toggle after two writes", mirror_swapped, 0);
        chk("R7", "read granted after commit", rd_gnt, 1);
        @(negedge clk);
        rd_req = 1'b0;
        chk("R8", "refetch not ready after 1 cycle", rd_valid, 0);
        @(negedge clk);
        chk("R8", "refetch valid after 2 cycles", rd_valid, 1);
        chk("R4", "identity restored data", rd_data, 32'hA5A5_0F0F);
        rd_check("R4", 20'h83FE8, ONES, 2);
    endtask

    initial begin
        t_reset();
        t_identity();
        t_program_and();
        t_priority();
        t_swap();
        t_ignored_write();
        t_pending();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule